// File: doc/BRIEF.md
# Debug-Port Instruction-Cache Load Command Decoder

This block sits behind a debug scan chain and turns a stream of serially shifted bits into instruction-cache maintenance requests. Bits arrive one per enabled clock. Every 33 of them form one packet, which the block presents internally as a parallel word. When the block is waiting for a command, the packet's 3-bit function field selects one of four operations. Two of them are invalidates, which act at once: one drops the line that holds a given virtual address, and the other empties the mini cache. The other two are loads, one for the main cache and one for the mini cache. A load then absorbs eight data packets and issues a single line-write request that carries the line address, the target cache and all eight instruction words.

A cache model on the other side samples the single-cycle request strobes and the address, target and line-data buses that go with them. An abort input, or the synchronous reset, drops a half-shifted packet and any load that is only partly collected, and puts the block back to waiting for a command.

Top module: `dbg_cache_loader`

## Requirements
- R1: Bits on `shift_in` are taken only in cycles with `shift_en` high, least significant packet bit first. A packet is complete on its 33rd taken bit. Idle cycles between bits do not disturb framing.
- R2: In a command packet, bit 32 is the valid flag, bits 31:29 are the function code and bits 28:2 are virtual address bits 31:5. `req_va` is that address with bits 4:0 zero.
- R3: A valid command with code 000 produces exactly one `inv_line_req` pulse, with `req_va` set from the packet, and no other strobe.
- R4: A valid command with code 001 produces exactly one `inv_mini_req` pulse and no other strobe, and leaves `req_va` unchanged. No branch-buffer flush or main-cache action is requested.
- R5: Codes 100 to 111 produce no strobe, and the block stays waiting for a command.
- R6: A valid command with code 010 is followed by eight data packets. After them exactly one `fill_req` pulse is issued, with `fill_mini` = 0 and `req_va` set from the command.
- R7: A valid command with code 011 behaves the same way but with `fill_mini` = 1.
- R8: In a data packet, bit 32 is valid and bits 31:0 are the instruction. The k-th accepted data word (k = 0..7) appears in `fill_data[32k+31:32k]`.
- R9: A packet with bit 32 clear is discarded, whether it arrives as a command or as data.
- R10: `fill_req` is a one-cycle pulse. It rises only in the cycle after the eighth data word is accepted, and never earlier.
- R11: `abort` drops a partial packet and a partial load, and the next packet is decoded as a command.
- R12: After reset all strobes are low, `req_va`, `fill_mini` and `fill_data` are zero, and the block waits for a command.
- R13: At most one of the three request strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| abort | input | 1 | Drops the partial packet and the partial load |
| shift_en | input | 1 | Qualifies `shift_in` |
| shift_in | input | 1 | Serial packet bit, LSB first |
| inv_line_req | output | 1 | Pulse: invalidate the line holding `req_va` |
| inv_mini_req | output | 1 | Pulse: invalidate the whole mini cache |
| fill_req | output | 1 | Pulse: write `fill_data` at `req_va` |
| fill_mini | output | 1 | Fill target: 0 main cache, 1 mini cache |
| req_va | output | 32 | Line-aligned virtual address |
| fill_data | output | 256 | Eight instruction words, word 0 in the low bits |

## Verification
The bench uses the default build: 32-bit words, eight-word lines and a 3-bit function code, so every packet is 33 bits. With these values all eight function codes can be swept, each with several addresses. Every load can also be run through its full nine packets, while idle gaps are mixed into the serial stream. The same build also brings within reach discarded data packets in the middle of a load, aborts both mid-packet and mid-load, and the check that the seventh word alone raises no fill.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_INV_LINE  = 3'b000,
    FN_INV_MINI  = 3'b001,
    FN_LOAD_MAIN = 3'b010,
    FN_LOAD_MINI = 3'b011
  } dcl_fn_e;

  // codes with the top bit set carry no operation
  function automatic logic fn_reserved(input logic [FUNC_W-1:0] fn);
    return fn[FUNC_W-1];
  endfunction

  function automatic logic fn_is_load(input logic [FUNC_W-1:0] fn);
    return (fn == FN_LOAD_MAIN) || (fn == FN_LOAD_MINI);
  endfunction
endpackage

// File: rtl/dcl_shifter.sv
module dcl_shifter #(
  parameter int PKT_W = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic             pkt_vld,
  output logic [PKT_W-1:0] pkt_word
);
  localparam int CNT_W = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PKT_W - 1);

  logic [PKT_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             last_bit_in;

  assign last_bit_in = shift_en && (cnt == LAST_BIT);
  assign pkt_word    = sr;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      sr      <= '0;
      cnt     <= '0;
      pkt_vld <= 1'b0;
    end else begin
      pkt_vld <= last_bit_in;
      if (shift_en) begin
        sr  <= {shift_in, sr[PKT_W-1:1]};
        cnt <= last_bit_in ? '0 : cnt + 1'b1;
      end
    end
  end

  // R1: a packet is only announced right after an enabled shift
  assert_pkt_after_shift_R1: assert property (@(posedge clk) disable iff (rst)
    pkt_vld |-> $past(shift_en));
  // R1: the bit counter never leaves the packet length
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(PKT_W));
  // R11: abort drops the partial packet
  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (cnt == '0) && !pkt_vld);
endmodule

// File: rtl/dcl_line_buf.sv
module dcl_line_buf #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  logic [$clog2(LINE_WORDS)-1:0] idx,
  input  logic [WORD_W-1:0]            data,
  output logic [LINE_WORDS*WORD_W-1:0] line
);
  localparam int IDX_W = $clog2(LINE_WORDS);

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (rst) slot <= '0;
      else if (wr && (idx == IDX_W'(g))) slot <= data;
    end
    assign line[g*WORD_W +: WORD_W] = slot;
  end
endmodule

// File: rtl/dcl_decoder.sv
module dcl_decoder
  import dcl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          abort,
  input  logic                          pkt_vld,
  input  logic [WORD_W:0]               pkt_word,
  output logic                          inv_line_req,
  output logic                          inv_mini_req,
  output logic                          fill_req,
  output logic                          fill_mini,
  output logic [WORD_W-1:0]             req_va,
  output logic                          word_wr,
  output logic [$clog2(LINE_WORDS)-1:0] word_idx,
  output logic [WORD_W-1:0]             word_data
);
  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int LINE_OB = $clog2(LINE_WORDS * WORD_W / 8);
  localparam int VA_W    = WORD_W - LINE_OB;
  localparam int VA_TOP  = WORD_W - 1 - FUNC_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

  typedef enum logic {ST_WAIT, ST_FILL} st_e;

  // line-aligned address carried by a command packet
  function automatic logic [WORD_W-1:0] cmd_va(input logic [WORD_W:0] w);
    return {w[VA_TOP -: VA_W], {LINE_OB{1'b0}}};
  endfunction

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic [FUNC_W-1:0] fn;
  logic             pkt_ok, cmd_accept, data_accept, last_word_wr;

  assign fn           = pkt_word[WORD_W-1 -: FUNC_W];
  assign pkt_ok       = pkt_vld && pkt_word[WORD_W];
  assign cmd_accept   = pkt_ok && (st == ST_WAIT);
  assign data_accept  = pkt_ok && (st == ST_FILL);
  assign last_word_wr = data_accept && (idx == LAST_IDX);
  assign word_wr      = data_accept;
  assign word_idx     = idx;
  assign word_data    = pkt_word[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_va    <= '0;
      fill_mini <= 1'b0;
    end else if (cmd_accept && !abort && !fn_reserved(fn) && fn != FN_INV_MINI) begin
      req_va    <= cmd_va(pkt_word);
      if (fn_is_load(fn)) fill_mini <= (fn == FN_LOAD_MINI);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st           <= ST_WAIT;
      idx          <= '0;
      inv_line_req <= 1'b0;
      inv_mini_req <= 1'b0;
      fill_req     <= 1'b0;
    end else begin
      inv_line_req <= 1'b0;
      inv_mini_req <= 1'b0;
      fill_req     <= 1'b0;
      if (cmd_accept) begin
        unique case (fn)
          FN_INV_LINE:  inv_line_req <= 1'b1;
          FN_INV_MINI:  inv_mini_req <= 1'b1;
          FN_LOAD_MAIN,
          FN_LOAD_MINI: begin
            st  <= ST_FILL;
            idx <= '0;
          end
          default: ;
        endcase
      end
      if (data_accept) begin
        idx <= idx + 1'b1;
        if (last_word_wr) begin
          fill_req <= 1'b1;
          st       <= ST_WAIT;
        end
      end
    end
  end

  // R13: strobes never overlap
  assert_strobe_onehot_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inv_line_req, inv_mini_req, fill_req}));
  // R10: a fill follows the eighth accepted word and nothing else
  assert_fill_after_last_R10: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> $past(last_word_wr));
  // R10: single-cycle fill pulse
  assert_fill_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> !fill_req);
  // R11: abort always lands in the command-wait state
  assert_abort_wait_R11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (st == ST_WAIT) && !fill_req);
  // R5: reserved codes leave no trace
  assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && fn_reserved(fn)) |=>
      (st == ST_WAIT) && !inv_line_req && !inv_mini_req && !fill_req);
  // R4: mini invalidate raises only its own strobe and keeps the address
  assert_mini_only_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_accept && !abort && fn == FN_INV_MINI) |=>
      inv_mini_req && !inv_line_req && !fill_req && $stable(req_va));
  // R9: a packet without its valid flag moves no word
  assert_invalid_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && !pkt_word[WORD_W] && !abort) |=> $stable(idx));
endmodule

// File: rtl/dbg_cache_loader.sv
module dbg_cache_loader #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         abort,
  input  logic                         shift_en,
  input  logic                         shift_in,
  output logic                         inv_line_req,
  output logic                         inv_mini_req,
  output logic                         fill_req,
  output logic                         fill_mini,
  output logic [WORD_W-1:0]            req_va,
  output logic [LINE_WORDS*WORD_W-1:0] fill_data
);
  localparam int PKT_W = WORD_W + 1;
  localparam int IDX_W = $clog2(LINE_WORDS);

  logic             pkt_vld;
  logic [PKT_W-1:0] pkt_word;
  logic             word_wr;
  logic [IDX_W-1:0] word_idx;
  logic [WORD_W-1:0] word_data;

  dcl_shifter #(.PKT_W(PKT_W)) u_shift (
    .clk(clk), .rst(rst), .abort(abort),
    .shift_en(shift_en), .shift_in(shift_in),
    .pkt_vld(pkt_vld), .pkt_word(pkt_word)
  );

  dcl_decoder #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_dec (
    .clk(clk), .rst(rst), .abort(abort),
    .pkt_vld(pkt_vld), .pkt_word(pkt_word),
    .inv_line_req(inv_line_req), .inv_mini_req(inv_mini_req),
    .fill_req(fill_req), .fill_mini(fill_mini), .req_va(req_va),
    .word_wr(word_wr), .word_idx(word_idx), .word_data(word_data)
  );

  dcl_line_buf #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk(clk), .rst(rst), .wr(word_wr), .idx(word_idx),
    .data(word_data), .line(fill_data)
  );
endmodule

// File: tb/dbg_cache_loader_tb.sv
module dbg_cache_loader_tb;
  logic clk = 1'b0;
  logic rst, abort, shift_en, shift_in;
  logic inv_line_req, inv_mini_req, fill_req, fill_mini;
  logic [31:0]  req_va;
  logic [255:0] fill_data;

  always #5 clk = ~clk;

  dbg_cache_loader u_dut (
    .clk(clk), .rst(rst), .abort(abort), .shift_en(shift_en), .shift_in(shift_in),
    .inv_line_req(inv_line_req), .inv_mini_req(inv_mini_req), .fill_req(fill_req),
    .fill_mini(fill_mini), .req_va(req_va), .fill_data(fill_data)
  );

  int n_chk = 0, n_bad = 0;
  int n_inv = 0, n_mini = 0, n_fill = 0, n_multi = 0, n_long = 0;
  logic [31:0]  cap_va;
  logic         cap_mini, prev_fill;
  logic [255:0] cap_data;
  logic [31:0]  exp_va;
  bit           done = 0;

  always @(negedge clk) begin
    if (rst) prev_fill <= 1'b0;
    else begin
      if (inv_line_req) begin n_inv++; cap_va = req_va; end
      if (inv_mini_req) n_mini++;
      if (fill_req) begin n_fill++; cap_va = req_va; cap_mini = fill_mini; cap_data = fill_data; end
      if ((32'(inv_line_req) + 32'(inv_mini_req) + 32'(fill_req)) > 1) n_multi++;
      if (fill_req && prev_fill) n_long++;
      prev_fill <= fill_req;
    end
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_inv = 0; n_mini = 0; n_fill = 0;
  endtask

  task automatic send_pkt(input logic [32:0] p, input bit gaps);
    for (int i = 0; i < 33; i++) begin
      @(negedge clk); shift_en = 1'b1; shift_in = p[i];
      if (gaps && (i % 5 == 2)) begin @(negedge clk); shift_en = 1'b0; shift_in = ~p[i]; end
    end
    @(negedge clk); shift_en = 1'b0; shift_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [32:0] cmd(input logic [2:0] fn, input logic [31:0] va);
    return {1'b1, fn, va[31:5], 2'b01};
  endfunction

  function automatic logic [31:0] dword(input logic [31:0] va, input int k);
    return va ^ (32'h0101_0101 * 32'(k + 1)) ^ 32'h5A00_00C3;
  endfunction

  task automatic print_summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      print_summary();
      $finish;
    end
  end

  initial begin
    logic [255:0] line;
    rst = 1'b1; abort = 1'b0; shift_en = 1'b0; shift_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12 strobes", {inv_line_req, inv_mini_req, fill_req}, 0);
    check("R12 va/mini", {fill_mini, req_va}, 0);
    check("R12 data", fill_data, 0);
    exp_va = 32'h0;

    // sweep all codes, several addresses, with and without idle gaps (R1)
    for (int code = 0; code < 8; code++) begin
      for (int a = 0; a < 4; a++) begin
        logic [31:0] va;
        va = (32'(code) * 32'h1357_9BDF + 32'(a) * 32'h0EAD_BEE1) & 32'hFFFF_FFE0;
        if (a == 3) va = 32'hFFFF_FFE0;
        clear_counts();
        send_pkt(cmd(3'(code), va), a[0]);
        if (code == 0) begin
          exp_va = va;
          check("R3 inv_line count", 256'(n_inv), 1);
          check("R2 R3 inv va", 256'(cap_va), 256'(va));
          check("R3 no other", 256'(n_mini + n_fill), 0);
        end else if (code == 1) begin
          check("R4 mini count", 256'(n_mini), 1);
          check("R4 no other", 256'(n_inv + n_fill), 0);
          check("R4 va kept", 256'(req_va), 256'(exp_va));
        end else if (code >= 4) begin
          check("R5 reserved quiet", 256'(n_inv + n_mini + n_fill), 0);
        end else begin
          exp_va = va;
          line = '0;
          for (int k = 0; k < 8; k++) begin
            line[k*32 +: 32] = dword(va, k);
            if (k == 3) send_pkt({1'b0, 32'hDEAD_BEEF}, 1'b0); // R9 dropped
            send_pkt({1'b1, dword(va, k)}, a[1]);
            if (k == 6) check("R10 no early fill", 256'(n_fill), 0);
          end
          check("R6 R7 fill count", 256'(n_fill), 1);
          check("R2 fill va", 256'(cap_va), 256'(va));
          check(code == 3 ? "R7 target mini" : "R6 target main", 256'(cap_mini), 256'(code == 3));
          check("R8 R9 line data", cap_data, line);
          check("R10 other strobes", 256'(n_inv + n_mini), 0);
        end
      end
    end

    // R9: command without valid flag is dropped
    clear_counts();
    send_pkt({1'b0, 3'b000, 27'h123_4567, 2'b00}, 1'b0);
    check("R9 cmd dropped", 256'(n_inv + n_mini + n_fill), 0);
    // R5: after reserved code, next packet is a command
    send_pkt(cmd(3'b110, 32'h0), 1'b0);
    send_pkt(cmd(3'b000, 32'h0000_4440), 1'b0);
    check("R5 waiting after reserved", 256'(n_inv), 1);
    check("R5 va after reserved", 256'(cap_va), 256'(32'h0000_4440));

    // R11: abort in the middle of a load
    clear_counts();
    send_pkt(cmd(3'b010, 32'h8000_0100), 1'b0);
    for (int k = 0; k < 3; k++) send_pkt({1'b1, dword(32'h0, k)}, 1'b0);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    send_pkt(cmd(3'b000, 32'h0BAD_0020), 1'b0);
    check("R11 cmd after abort", 256'(n_inv), 1);
    check("R11 va after abort", 256'(cap_va), 256'(32'h0BAD_0020));
    for (int k = 0; k < 5; k++) send_pkt({1'b1, 3'b111, 29'(k)}, 1'b0);
    check("R11 no fill after abort", 256'(n_fill), 0);

    // R11 R1: abort mid-packet drops the partial bits
    clear_counts();
    for (int i = 0; i < 10; i++) begin @(negedge clk); shift_en = 1'b1; shift_in = 1'b1; end
    @(negedge clk); shift_en = 1'b0; abort = 1'b1; @(negedge clk); abort = 1'b0;
    send_pkt(cmd(3'b000, 32'h7777_77E0), 1'b1);
    check("R11 R1 framing restart", 256'(cap_va), 256'(32'h7777_77E0));
    check("R11 one strobe", 256'(n_inv + n_mini + n_fill), 1);

    check("R13 overlap", 256'(n_multi), 0);
    check("R10 pulse width", 256'(n_long), 0);
    done = 1;
    print_summary();
    $finish;
  end
endmodule